// File: doc/BRIEF.md
# Clock-Master Synchronous Serial Receiver

This block receives serial bytes from a peripheral that cannot clock itself. The block generates the shift clock, samples one data line on each rising edge of that clock and assembles 8-bit frames. The first bit received becomes bit 0 of the byte. A completed frame is handed to a single receive buffer that the host reads through a one-cycle read strobe. A buffer-full flag and a one-cycle interrupt pulse tell the host that a byte is waiting.

Flow control is done by withholding the clock rather than by dropping data. With double buffering off, the receiver clocks in one frame and then idles until the host has read that byte, so each read requests exactly one further frame. With double buffering on, the shifter starts the next frame as soon as a byte reaches the buffer. If the buffer is still unread when that next frame ends, the new byte is held in the shifter and the clock stops. The next host read moves the held byte into the buffer and restarts clocking. The clock idles high, and the length of each clock phase, counted in system cycles, is a parameter.

Top module: `cmrx_top`

## Requirements
- R1: During and right after reset, `sclkOut` is high, `bufFull` is 0, `rxIrq` is 0 and `rxData` is 0.
- R2: While `rxEnable` is low at a frame boundary, `sclkOut` stays high. Once `rxEnable` is set, clocking starts; each frame has exactly 8 rising edges, and each low phase and each high phase lasts `DIV_HALF` system cycles.
- R3: `sdIn` is sampled on each rising edge of `sclkOut`; the bit taken at the first rising edge of a frame appears as `rxData[0]` and the bit at the eighth as `rxData[7]`.
- R4: When a frame completes and the buffer is empty, the byte appears on `rxData`, `bufFull` becomes 1 and `rxIrq` pulses in the same cycle.
- R5: With `dblBuf` = 0, no clock edges are issued after a completed frame until the host reads the buffer; each such read starts exactly one new frame.
- R6: With `dblBuf` = 1, the next frame starts right after a byte enters the empty buffer, without waiting for a read.
- R7: With `dblBuf` = 1, a frame that completes while `bufFull` is 1 raises no interrupt, leaves `rxData` unchanged and stops `sclkOut` high.
- R8: A read (`rdStrobe` high while `bufFull` is 1) while a byte is held in the shifter moves that byte to `rxData` on the next cycle, keeps `bufFull` at 1, pulses `rxIrq` and resumes clocking if `rxEnable` is set.
- R9: A read while no byte is held clears `bufFull` without an interrupt and leaves `rxData` unchanged; a read strobe while `bufFull` is 0 changes nothing.
- R10: Clearing `rxEnable` in the middle of a frame lets that frame finish with all 8 edges, then clocking stops; buffered and held bytes are kept and delivered by later reads.
- R11: `rxIrq` is high for exactly one system cycle per delivered byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxEnable | input | 1 | Allows new frames to start at frame boundaries |
| dblBuf | input | 1 | 1 = keep receiving while the buffer holds a byte |
| sdIn | input | 1 | Serial data from the peripheral |
| rdStrobe | input | 1 | One-cycle host read of `rxData` |
| sclkOut | output | 1 | Generated shift clock, idles high |
| rxData | output | FRAME_BITS | Receive buffer contents |
| bufFull | output | 1 | Receive buffer holds an unread byte |
| rxIrq | output | 1 | One-cycle pulse when a byte enters the buffer |

## Verification
A lost or stale held-byte flag has two possible effects. The clock may restart while a byte is still waiting, and the next read then delivers a wrong or duplicate byte. Or the clock may stay frozen after a read. Either effect appears within one frame time of the read, as an extra or missing group of eight clock edges. A shifter that is misaligned or reversed gives a wrong `rxData` in the same cycle as the interrupt. A wrong buffer-full state causes a spurious or missing interrupt, or a flag that does not clear, on the first read that follows.

// File: rtl/cmrx_pkg.sv
package cmrx_pkg;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic sample;     // take sdIn into the shifter
    logic loadBuf;    // copy the shifter into the receive buffer
    logic clearFull;  // host consumed the buffer, nothing to replace it
  } cmrxStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,   // frame boundary, clock high
    ST_LOW  = 2'd1,   // clock low phase
    ST_HIGH = 2'd2    // clock high phase
  } cmrxState_e;

endpackage

// File: rtl/cmrx_datapath.sv
module cmrx_datapath
  import cmrx_pkg::*;
#(
  parameter int FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cmrxStrobes_t          strobes,
  input  logic                  sdIn,
  output logic [FRAME_BITS-1:0] rxData,
  output logic                  bufFull,
  output logic                  rxIrq
);

  logic [FRAME_BITS-1:0] shiftReg;
  logic [FRAME_BITS-1:0] bufReg;
  logic                  fullReg;
  logic                  irqReg;

  // The first bit enters at the top and walks down to bit 0.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobes.sample) begin
      shiftReg <= {sdIn, shiftReg[FRAME_BITS-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufReg  <= '0;
      fullReg <= 1'b0;
      irqReg  <= 1'b0;
    end else begin
      irqReg <= strobes.loadBuf;
      if (strobes.loadBuf) begin
        bufReg  <= shiftReg;
        fullReg <= 1'b1;
      end else if (strobes.clearFull) begin
        fullReg <= 1'b0;
      end
    end
  end

  assign rxData  = bufReg;
  assign bufFull = fullReg;
  assign rxIrq   = irqReg;

endmodule

// File: rtl/cmrx_control.sv
module cmrx_control
  import cmrx_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int DIV_HALF   = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         rxEnable,
  input  logic         dblBuf,
  input  logic         rdStrobe,
  input  logic         bufFull,
  output cmrxStrobes_t strobes,
  output logic         sclkOut
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS);
  localparam logic [DIV_W-1:0] DIV_END  = DIV_W'(DIV_HALF - 1);

  cmrxState_e       state;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             sclkReg;
  logic             parked;

  logic phaseEnd;
  logic complete;
  logic rdHit;
  logic run;

  always_comb begin
    phaseEnd = (divCnt == DIV_END);
    // First cycle of the high phase after the last sample.
    complete = (state == ST_HIGH) && (bitCnt == LAST_BIT) && (divCnt == '0);
    rdHit    = rdStrobe && bufFull;
    // In single-buffer mode a full buffer holds off the next frame.
    run      = rxEnable && !parked && (dblBuf || !bufFull);

    strobes.sample    = (state == ST_LOW) && phaseEnd;
    strobes.loadBuf   = (complete && (!bufFull || rdStrobe)) || (rdHit && parked);
    strobes.clearFull = rdHit && !strobes.loadBuf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      bitCnt  <= '0;
      sclkReg <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (run) begin
            state   <= ST_LOW;
            sclkReg <= 1'b0;
            divCnt  <= '0;
            bitCnt  <= '0;
          end
        end
        ST_LOW: begin
          if (phaseEnd) begin
            state   <= ST_HIGH;
            sclkReg <= 1'b1;
            divCnt  <= '0;
            bitCnt  <= bitCnt + 1'b1;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (phaseEnd) begin
            divCnt <= '0;
            if (bitCnt == LAST_BIT) begin
              state <= ST_IDLE;
            end else begin
              state   <= ST_LOW;
              sclkReg <= 1'b0;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: begin
          state   <= ST_IDLE;
          sclkReg <= 1'b1;
        end
      endcase
    end
  end

  // A byte waiting in the shifter for the buffer to be read.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parked <= 1'b0;
    end else if (complete && bufFull && !rdStrobe) begin
      parked <= 1'b1;
    end else if (rdHit && parked) begin
      parked <= 1'b0;
    end
  end

  assign sclkOut = sclkReg;

endmodule

// File: rtl/cmrx_top.sv
module cmrx_top
  import cmrx_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int DIV_HALF   = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rxEnable,
  input  logic                  dblBuf,
  input  logic                  sdIn,
  input  logic                  rdStrobe,
  output logic                  sclkOut,
  output logic [FRAME_BITS-1:0] rxData,
  output logic                  bufFull,
  output logic                  rxIrq
);

  cmrxStrobes_t strobes;

  cmrx_control #(
    .FRAME_BITS(FRAME_BITS),
    .DIV_HALF  (DIV_HALF)
  ) u_control (
    .clk     (clk),
    .rstN    (rstN),
    .rxEnable(rxEnable),
    .dblBuf  (dblBuf),
    .rdStrobe(rdStrobe),
    .bufFull (bufFull),
    .strobes (strobes),
    .sclkOut (sclkOut)
  );

  cmrx_datapath #(
    .FRAME_BITS(FRAME_BITS)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .sdIn   (sdIn),
    .rxData (rxData),
    .bufFull(bufFull),
    .rxIrq  (rxIrq)
  );

endmodule

// File: rtl/cmrx_checker.sv
module cmrx_checker #(
  parameter int FRAME_BITS = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  rdStrobe,
  input logic                  bufFull,
  input logic                  rxIrq,
  input logic [FRAME_BITS-1:0] rxData
);

  // R11: the interrupt never lasts two cycles
  a_r11_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq);

  // R4: an interrupt always comes with a full buffer
  a_r4_irq_full: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> bufFull);

  // R9: the buffer empties only because of a host read
  a_r9_clear_on_read: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bufFull) |-> $past(rdStrobe));

  // R7: buffer contents change only together with an interrupt
  a_r7_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxData) |-> rxIrq);

endmodule

bind cmrx_top cmrx_checker #(.FRAME_BITS(FRAME_BITS)) u_checker (
  .clk     (clk),
  .rstN    (rstN),
  .rdStrobe(rdStrobe),
  .bufFull (bufFull),
  .rxIrq   (rxIrq),
  .rxData  (rxData)
);

// File: tb/tb_cmrx_top.sv
`timescale 1ns/1ps
module tb_cmrx_top;

  localparam int H = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxEnable = 1'b0;
  logic       dblBuf = 1'b0;
  logic       sdIn = 1'b0;
  logic       rdStrobe = 1'b0;
  logic       sclkOut;
  logic [7:0] rxData;
  logic       bufFull;
  logic       rxIrq;

  int checks = 0;
  int errors = 0;
  int edgeCnt = 0, edgeBase = 0;
  int irqCnt = 0, irqBase = 0;
  int bitPtr = 0, frameBase = 0;
  int cyc = 0;
  logic [7:0] txBytes [16];

  cmrx_top #(.FRAME_BITS(8), .DIV_HALF(H)) dut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .dblBuf(dblBuf),
    .sdIn(sdIn), .rdStrobe(rdStrobe), .sclkOut(sclkOut),
    .rxData(rxData), .bufFull(bufFull), .rxIrq(rxIrq)
  );

  always #2.5 clk = ~clk;

  // Peripheral model: next bit presented on each falling clock edge.
  always @(negedge sclkOut) begin
    sdIn   <= txBytes[(bitPtr / 8) % 16][bitPtr % 8];
    bitPtr <= bitPtr + 1;
  end

  always @(posedge sclkOut) edgeCnt <= edgeCnt + 1;

  always @(posedge clk) begin
    if (rxIrq === 1'b1) irqCnt <= irqCnt + 1;
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int edges();
    return edgeCnt - edgeBase;
  endfunction

  function automatic int irqs();
    return irqCnt - irqBase;
  endfunction

  function automatic logic [7:0] expByte(input int k);
    return txBytes[(frameBase + k) % 16];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic applyReset();
    rstN = 1'b0; rxEnable = 1'b0; dblBuf = 1'b0; rdStrobe = 1'b0;
    repeat (3) @(negedge clk);
    check(sclkOut === 1'b1, "R1 sclk in reset", sclkOut, 1);
    rstN = 1'b1;
    @(negedge clk);
    edgeBase  = edgeCnt;
    irqBase   = irqCnt;
    frameBase = bitPtr / 8;
    check(sclkOut === 1'b1, "R1 sclk after reset", sclkOut, 1);
    check(bufFull === 1'b0, "R1 bufFull after reset", bufFull, 0);
    check(rxIrq === 1'b0, "R1 rxIrq after reset", rxIrq, 0);
    check(rxData === 8'h00, "R1 rxData after reset", rxData, 0);
  endtask

  task automatic waitIrq(input string req);
    int n = 0;
    while (rxIrq !== 1'b1 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(n < 2000, req, n, 0);
    @(negedge clk);
    check(rxIrq === 1'b0, "R11 irq one cycle", rxIrq, 0);
  endtask

  task automatic hostRead();
    @(negedge clk) rdStrobe = 1'b1;
    @(negedge clk) rdStrobe = 1'b0;
  endtask

  task automatic tIdle();
    applyReset();
    repeat (30) @(negedge clk);
    check(edges() == 0, "R2 no clock while disabled", edges(), 0);
    check(sclkOut === 1'b1, "R2 idle high", sclkOut, 1);
  endtask

  task automatic tSingle();
    int lowLen = 0;
    int highLen = 0;
    applyReset();
    dblBuf = 1'b0;
    rxEnable = 1'b1;
    while (sclkOut === 1'b1 && lowLen < 20) begin
      @(negedge clk);
      lowLen++;
    end
    lowLen = 0;
    while (sclkOut === 1'b0 && lowLen < 20) begin
      @(negedge clk);
      lowLen++;
    end
    while (sclkOut === 1'b1 && highLen < 20) begin
      @(negedge clk);
      highLen++;
    end
    check(lowLen == H, "R2 low phase length", lowLen, H);
    check(highLen == H, "R2 high phase length", highLen, H);
    waitIrq("R4 first frame irq");
    check(rxData === expByte(0), "R3 lsb-first byte 0", rxData, expByte(0));
    check(bufFull === 1'b1, "R4 bufFull set", bufFull, 1);
    check(edges() == 8, "R2 eight edges per frame", edges(), 8);
    repeat (60) @(negedge clk);
    check(edges() == 8, "R5 no clock until read", edges(), 8);
    check(sclkOut === 1'b1, "R5 clock parked high", sclkOut, 1);
    hostRead();
    check(bufFull === 1'b0, "R9 read clears full", bufFull, 0);
    check(rxIrq === 1'b0, "R9 no irq on plain read", rxIrq, 0);
    waitIrq("R5 read starts a frame");
    check(rxData === expByte(1), "R3 byte 1", rxData, expByte(1));
    check(edges() == 16, "R5 one frame per read", edges(), 16);
    repeat (60) @(negedge clk);
    check(edges() == 16, "R5 stopped again", edges(), 16);
    hostRead();
    waitIrq("R5 second read frame");
    check(rxData === expByte(2), "R3 byte 2", rxData, expByte(2));
    check(edges() == 24, "R5 third frame edges", edges(), 24);
    rxEnable = 1'b0;
    hostRead();
    repeat (10) @(negedge clk);
  endtask

  task automatic tDouble();
    applyReset();
    dblBuf = 1'b1;
    rxEnable = 1'b1;
    waitIrq("R4 double first irq");
    check(rxData === expByte(0), "R3 double byte 0", rxData, expByte(0));
    repeat (10) @(negedge clk);
    check(edges() > 8, "R6 continues without read", edges(), 9);
    repeat (200) @(negedge clk);
    check(edges() == 16, "R7 clock stops after held frame", edges(), 16);
    check(sclkOut === 1'b1, "R7 stopped high", sclkOut, 1);
    check(irqs() == 1, "R7 no irq for held frame", irqs(), 1);
    check(rxData === expByte(0), "R7 buffer unchanged", rxData, expByte(0));
    hostRead();
    check(rxIrq === 1'b1, "R8 irq on transfer", rxIrq, 1);
    check(rxData === expByte(1), "R8 held byte moved", rxData, expByte(1));
    check(bufFull === 1'b1, "R8 full stays set", bufFull, 1);
    repeat (6) @(negedge clk);
    check(edges() > 16, "R8 clocking resumes", edges(), 17);
    rxEnable = 1'b0;
    repeat (200) @(negedge clk);
    check(edges() == 24, "R10 frame finishes then stops", edges(), 24);
    check(rxData === expByte(1), "R10 buffer intact", rxData, expByte(1));
    hostRead();
    check(rxIrq === 1'b1, "R10 held byte delivered", rxIrq, 1);
    check(rxData === expByte(2), "R10 held byte value", rxData, expByte(2));
    repeat (50) @(negedge clk);
    check(edges() == 24, "R10 no restart while disabled", edges(), 24);
    hostRead();
    check(bufFull === 1'b0, "R9 final read clears", bufFull, 0);
    check(rxIrq === 1'b0, "R9 no irq", rxIrq, 0);
    check(rxData === expByte(2), "R9 data unchanged", rxData, expByte(2));
    hostRead();
    check(bufFull === 1'b0, "R9 empty read ignored", bufFull, 0);
    check(rxIrq === 1'b0, "R9 empty read no irq", rxIrq, 0);
    check(irqs() == 3, "R11 one irq per byte", irqs(), 3);
  endtask

  initial begin
    txBytes[0]  = 8'hA5; txBytes[1]  = 8'h3C; txBytes[2]  = 8'h01; txBytes[3]  = 8'h80;
    txBytes[4]  = 8'hFF; txBytes[5]  = 8'h00; txBytes[6]  = 8'h5A; txBytes[7]  = 8'hC3;
    txBytes[8]  = 8'h96; txBytes[9]  = 8'h7E; txBytes[10] = 8'h12; txBytes[11] = 8'hE8;
    txBytes[12] = 8'h4D; txBytes[13] = 8'hB1; txBytes[14] = 8'h69; txBytes[15] = 8'h2F;
    tIdle();
    tSingle();
    tDouble();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule